// File: doc/BRIEF.md
# Ethernet Transmit Width Gasket

This block sits between a DMA engine and a gigabit byte-stream transmit path. On a slow write clock it accepts 32-bit words that carry the frame data. On a faster transmit clock it hands the same data on as one byte per cycle. The two sides are joined by an asynchronous FIFO. Its write and read pointers cross the clock boundary as Gray codes through two-flop synchronisers. A count of completed frames crosses the boundary in the same way.

The byte side has no way to wait once a frame has begun. For that reason the gasket holds a frame back until it can stream without gaps: either the whole frame is already in the FIFO, or a configurable number of words is buffered. If the buffer still runs dry in the middle of a frame, the gasket marks that frame as bad on the error line and does not stretch it. It then throws away the rest of that frame and resumes with the next one. Between any two frames the transmit side stays idle for a fixed minimum number of byte cycles.

The last word of each frame carries a small field that gives how many of its bytes are real. Frames can therefore have any byte length. The write side reaches its rated throughput when it offers a word on every write cycle, and that throughput is higher than the rate at which bytes drain.

Top module: `txg_gasket`

## Requirements
- R1: `in_ready` is low exactly while the FIFO holds DEPTH (16) words. A word is taken only on a write edge with `in_valid` and `in_ready` both high, and no taken word is ever lost or repeated.
- R2: Bytes leave in the order the words were taken. Within a word the order is bits 7:0 first, then 15:8, then 23:16, and bits 31:24 last.
- R3: On the word with `in_last`=1, `in_bytes` holds the number of valid bytes minus one (0 means 1 byte, 3 means 4 bytes). Only that many low-order bytes are sent, and the unused high bytes never appear.
- R4: `in_bytes` has no effect on words with `in_last`=0. All four bytes of such a word are sent.
- R5: Once `tx_en` rises for a frame, it stays high on every consecutive cycle until the last byte of that frame, unless an error cycle ends the frame. The FIFO is never read while empty.
- R6: A frame shorter than START_WORDS (4) words does not begin on the byte side until its final word has been taken.
- R7: A frame begins as soon as START_WORDS words of it are buffered, even if its final word has not yet arrived.
- R8: If the next word of a started frame is not available when it is needed, the block emits exactly one cycle with `tx_en`=1 and `tx_er`=1, and `tx_en` is low on the following cycle. The remaining words of that frame, up to and including its final word, are discarded. The next frame is sent intact.
- R9: After the last byte or error cycle of a frame, at least IFG (12) cycles with `tx_en` low pass before the next frame's first byte.
- R10: When each frame's words are offered on every write cycle, no error cycle occurs.
- R11: While either reset is held, and right after reset, `tx_en`, `tx_er` and `txd` are zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side reset, active low, asynchronous assert |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The FIFO has space and the word will be taken |
| in_data | input | 32 | Frame data, first byte in bits 7:0 |
| in_last | input | 1 | This word ends the frame |
| in_bytes | input | 2 | Valid bytes minus one; only read on the last word |
| tx_clk | input | 1 | Transmit byte clock |
| tx_rst_n | input | 1 | Transmit-side reset, active low, asynchronous assert |
| tx_en | output | 1 | A frame byte or an error cycle is being presented |
| tx_er | output | 1 | The current frame is corrupt because of starvation |
| txd | output | 8 | Transmit byte |

## Verification
The bench sends frames whose lengths end on each of the four final-word byte counts, and it puts junk in the unused bytes and in the byte-count field of non-final words. A design that read the field on every word would drop bytes, and one that ignored it on the last word would leak junk. One short frame is written with long pauses between its words, which catches a design that starts on partial data and would then fail with an error or a bubble. One long frame is stalled after six words, which forces exactly one error cycle and a discard; a design that recovered badly would either leak the stale words into the next frame or hang. A 200-byte frame fills the FIFO to prove that backpressure loses nothing, and back-to-back short frames probe the minimum idle gap.

// File: rtl/txg_pkg.sv
package txg_pkg;

    // One FIFO entry: frame data, end-of-frame flag and valid-byte count minus one.
    typedef struct packed {
        logic        last;
        logic [1:0]  nb_m1;
        logic [31:0] data;
    } txg_word_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEND,
        S_STARVE,
        S_DRAIN,
        S_GAP
    } txg_state_e;

endpackage

// File: rtl/txg_sync.sv
// Two-flop synchroniser for a Gray-coded vector.
module txg_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/txg_mem.sv
// FIFO storage: written on the write clock, read combinationally from the transmit side.
module txg_mem #(
    parameter int DEPTH = 16,
    parameter int W     = 35,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/txg_wr_ctrl.sv
// Write-side pointer, full detection and completed-frame counter.
module txg_wr_ctrl #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic [PW-1:0] rgray_sync,
    output logic          in_ready,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic [PW-1:0] fgray
);
    typedef struct packed {
        logic [PW-1:0] wbin;
        logic [PW-1:0] wgray;
        logic [PW-1:0] fbin;
        logic [PW-1:0] fgray;
        logic          fpend;
    } wr_t;

    wr_t           st_d, st_q;
    logic          full;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] lvl;

    always_comb begin
        for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_sync >> i);
    end

    always_comb begin
        full  = (st_q.wgray == {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]});
        we    = in_valid && !full;
        st_d  = st_q;
        st_d.wbin  = st_q.wbin + PW'(we);
        st_d.wgray = st_d.wbin ^ (st_d.wbin >> 1);
        // The frame count moves one write cycle after the word pointer,
        // so the word pointer is always visible first on the far side.
        st_d.fpend = we && in_last;
        if (st_q.fpend) begin
            st_d.fbin  = st_q.fbin + 1'b1;
        end
        st_d.fgray = st_d.fbin ^ (st_d.fbin >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready = !full;
    assign waddr    = st_q.wbin[AW-1:0];
    assign wgray    = st_q.wgray;
    assign fgray    = st_q.fgray;
    assign lvl      = st_q.wbin - rbin_s;

    // R1: the write side never believes it holds more than DEPTH words
    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(lvl) <= DEPTH);
endmodule

// File: rtl/txg_rd_ctrl.sv
// Transmit-side read pointer, fill level and frame start decision.
module txg_rd_ctrl #(
    parameter int DEPTH       = 16,
    parameter int START_WORDS = 4,
    parameter int AW          = $clog2(DEPTH),
    parameter int PW          = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] wgray_sync,
    input  logic [PW-1:0] fgray_sync,
    input  logic          pop,
    input  logic          pop_last,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic          empty,
    output logic          go
);
    typedef struct packed {
        logic [PW-1:0] rbin;
        logic [PW-1:0] rgray;
        logic [PW-1:0] cons;
    } rd_t;

    rd_t           st_d, st_q;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] fbin_s;
    logic [PW-1:0] level;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            wbin_s[i] = ^(wgray_sync >> i);
            fbin_s[i] = ^(fgray_sync >> i);
        end
    end

    always_comb begin
        level = wbin_s - st_q.rbin;
        empty = (level == '0);
        go    = !empty && ((fbin_s != st_q.cons) || (int'(level) >= START_WORDS));
        st_d  = st_q;
        st_d.rbin  = st_q.rbin + PW'(pop);
        st_d.rgray = st_d.rbin ^ (st_d.rbin >> 1);
        st_d.cons  = st_q.cons + PW'(pop_last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr = st_q.rbin[AW-1:0];
    assign rgray = st_q.rgray;

    // R5: the serializer never reads a word that is not there
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/txg_serializer.sv
// Word-to-byte serializer with frame gating, starvation handling and gap timing.
module txg_serializer
    import txg_pkg::*;
#(
    parameter int IFG = 12,
    parameter int GW  = $clog2(IFG),
    parameter int IW  = $clog2(IFG + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  txg_word_t head,
    input  logic      empty,
    input  logic      go,
    output logic      pop,
    output logic      pop_last,
    output logic      tx_en,
    output logic      tx_er,
    output logic [7:0] txd
);
    typedef struct packed {
        txg_state_e    st;
        txg_word_t     cur;
        logic [1:0]    idx;
        logic [GW-1:0] gap;
        logic [IW-1:0] idle;
        logic          en;
        logic          er;
        logic [7:0]    d;
    } ser_t;

    ser_t st_d, st_q;
    logic word_end;

    always_comb begin
        st_d     = st_q;
        pop      = 1'b0;
        st_d.en  = 1'b0;
        st_d.er  = 1'b0;
        st_d.d   = '0;
        word_end = st_q.cur.last ? (st_q.idx == st_q.cur.nb_m1) : (st_q.idx == 2'd3);

        unique case (st_q.st)
            S_IDLE: begin
                if (go) begin
                    pop       = 1'b1;
                    st_d.cur  = head;
                    st_d.idx  = '0;
                    st_d.st   = S_SEND;
                end
            end
            S_SEND: begin
                st_d.en = 1'b1;
                st_d.d  = st_q.cur.data[{st_q.idx, 3'b000} +: 8];
                if (!word_end) begin
                    st_d.idx = st_q.idx + 1'b1;
                end else if (st_q.cur.last) begin
                    st_d.st  = S_GAP;
                    st_d.gap = '0;
                end else if (!empty) begin
                    pop      = 1'b1;
                    st_d.cur = head;
                    st_d.idx = '0;
                end else begin
                    st_d.st  = S_STARVE;
                end
            end
            S_STARVE: begin
                st_d.en = 1'b1;
                st_d.er = 1'b1;
                st_d.st = S_DRAIN;
            end
            S_DRAIN: begin
                if (!empty) begin
                    pop = 1'b1;
                    if (head.last) begin
                        st_d.st  = S_GAP;
                        st_d.gap = '0;
                    end
                end
            end
            S_GAP: begin
                if (st_q.gap == GW'(IFG - 2)) st_d.st  = S_IDLE;
                else                          st_d.gap = st_q.gap + 1'b1;
            end
            default: st_d.st = S_IDLE;
        endcase

        // Run length of idle output cycles, saturating at IFG
        if (st_q.en)                    st_d.idle = '0;
        else if (st_q.idle != IW'(IFG)) st_d.idle = st_q.idle + 1'b1;

        pop_last = pop && head.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.st   <= S_IDLE;
            st_q.idle <= IW'(IFG);
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_en = st_q.en;
    assign tx_er = st_q.er;
    assign txd   = st_q.d;

    // R8: an error cycle is always the final cycle of its frame
    p_err_ends_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.er |=> !st_q.en);

    // R9: a frame only starts after at least IFG idle output cycles
    p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.en) |-> (int'(st_q.idle) >= IFG));
endmodule

// File: rtl/txg_gasket.sv
module txg_gasket
    import txg_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int START_WORDS = 4,
    parameter int IFG         = 12
) (
    input  logic        wr_clk,
    input  logic        wr_rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    input  logic        in_last,
    input  logic [1:0]  in_bytes,
    input  logic        tx_clk,
    input  logic        tx_rst_n,
    output logic        tx_en,
    output logic        tx_er,
    output logic [7:0]  txd
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int W  = $bits(txg_word_t);

    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, fgray, rgray;
    logic [PW-1:0] wgray_s, fgray_s, rgray_s;
    logic          empty, go, pop, pop_last;
    txg_word_t     wword, head;

    assign wword = '{last: in_last, nb_m1: in_bytes, data: in_data};

    txg_wr_ctrl #(.DEPTH(DEPTH)) wr_ctrl_i (
        .clk        (wr_clk),
        .rst_n      (wr_rst_n),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .rgray_sync (rgray_s),
        .in_ready   (in_ready),
        .we         (we),
        .waddr      (waddr),
        .wgray      (wgray),
        .fgray      (fgray)
    );

    txg_mem #(.DEPTH(DEPTH), .W(W)) mem_i (
        .wr_clk (wr_clk),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wword),
        .raddr  (raddr),
        .rdata  (head)
    );

    txg_sync #(.W(PW)) sync_wptr_i (.clk(tx_clk), .rst_n(tx_rst_n), .d(wgray), .q(wgray_s));
    txg_sync #(.W(PW)) sync_frm_i  (.clk(tx_clk), .rst_n(tx_rst_n), .d(fgray), .q(fgray_s));
    txg_sync #(.W(PW)) sync_rptr_i (.clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s));

    txg_rd_ctrl #(.DEPTH(DEPTH), .START_WORDS(START_WORDS)) rd_ctrl_i (
        .clk        (tx_clk),
        .rst_n      (tx_rst_n),
        .wgray_sync (wgray_s),
        .fgray_sync (fgray_s),
        .pop        (pop),
        .pop_last   (pop_last),
        .raddr      (raddr),
        .rgray      (rgray),
        .empty      (empty),
        .go         (go)
    );

    txg_serializer #(.IFG(IFG)) ser_i (
        .clk      (tx_clk),
        .rst_n    (tx_rst_n),
        .head     (head),
        .empty    (empty),
        .go       (go),
        .pop      (pop),
        .pop_last (pop_last),
        .tx_en    (tx_en),
        .tx_er    (tx_er),
        .txd      (txd)
    );
endmodule

// File: tb/txg_gasket_tb_top.sv
`timescale 1ns/1ps
module txg_gasket_tb_top;
    localparam int IFG = 12;

    logic        wr_clk = 1'b0, tx_clk = 1'b0;
    logic        wr_rst_n = 1'b0, tx_rst_n = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [31:0] in_data = '0;
    logic [1:0]  in_bytes = '0;
    logic        in_ready, tx_en, tx_er;
    logic [7:0]  txd;

    always #5  tx_clk = ~tx_clk;   // 100 MHz byte side
    always #12 wr_clk = ~wr_clk;   // slower word side

    txg_gasket dut_i (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_bytes(in_bytes),
        .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model state
    logic [7:0] exp_b[$];
    int         exp_len[$];
    int         exp_kind[$];   // 0 plain, 1 slow short, 2 stalled long
    bit         frame_done[64];
    int         nwr = 0;
    bit         model_on = 0;
    bit         in_fr = 0, err_fr = 0;
    int         fr_id = 0, fr_pos = 0, fr_len = 0, fr_kind = 0;
    int         idle_run = 1000, frames_out = 0, errs_out = 0;
    int         ready_low = 0;

    function automatic logic [7:0] pat(input int id, input int i);
        return 8'((id * 37 + i * 13 + 5) & 255);
    endfunction

    always @(negedge wr_clk) if (in_valid && !in_ready) ready_low++;

    always @(negedge tx_clk) begin
        if (model_on) begin
            if (tx_en) begin
                if (!in_fr) begin
                    if (exp_len.size() == 0) begin
                        chk(0, "R2 unexpected frame", 1, 0);
                    end else begin
                        fr_len  = exp_len.pop_front();
                        fr_kind = exp_kind.pop_front();
                        fr_pos  = 0;
                        in_fr   = 1;
                        chk(idle_run >= IFG, "R9 idle gap", idle_run, IFG);
                        if (fr_kind == 1) chk(frame_done[fr_id], "R6 early start", 0, 1);
                        if (fr_kind == 2) chk(!frame_done[fr_id], "R7 threshold start", 1, 0);
                    end
                end
                if (in_fr) begin
                    if (tx_er) begin
                        errs_out++;
                        chk(fr_kind == 2, "R10 unexpected error", fr_kind, 2);
                        chk(!err_fr, "R8 second error cycle", 1, 0);
                        while (fr_pos < fr_len) begin void'(exp_b.pop_front()); fr_pos++; end
                        err_fr = 1;
                    end else begin
                        chk(fr_pos < fr_len && !err_fr, "R3 extra byte", fr_pos, fr_len);
                        if (fr_pos < fr_len && !err_fr) begin
                            logic [7:0] e;
                            e = exp_b.pop_front();
                            if (fr_pos >= ((fr_len - 1) / 4) * 4)
                                chk(txd == e, "R3 final word byte", int'(txd), int'(e));
                            else
                                chk(txd == e, "R2 R4 byte order", int'(txd), int'(e));
                            fr_pos++;
                        end
                    end
                end
                idle_run = 0;
            end else begin
                if (in_fr) begin
                    if (!err_fr) chk(fr_pos == fr_len, "R5 frame cut or bubble", fr_pos, fr_len);
                    if (fr_kind == 2) chk(err_fr, "R8 starved frame not flagged", 0, 1);
                    in_fr = 0; err_fr = 0; fr_id++; frames_out++;
                end
                chk(!tx_er, "R8 error without enable", 1, 0);
                idle_run++;
            end
        end
    end

    task automatic send_frame(input int len, input int kind, input int stall_at,
                              input int stall_cyc, input int between);
        int id, words;
        id = nwr; nwr++;
        words = (len + 3) / 4;
        for (int i = 0; i < len; i++) exp_b.push_back(pat(id, i));
        exp_len.push_back(len);
        exp_kind.push_back(kind);
        for (int w = 0; w < words; w++) begin
            int gapc;
            bit ok;
            gapc = (w == stall_at) ? stall_cyc : ((w > 0) ? between : 0);
            if (gapc > 0) begin
                @(negedge wr_clk); in_valid = 1'b0;
                repeat (gapc) @(posedge wr_clk);
            end
            @(negedge wr_clk);
            for (int k = 0; k < 4; k++)
                in_data[8*k +: 8] = (4*w + k < len) ? pat(id, 4*w + k) : 8'hEE;
            in_last  = (w == words - 1);
            in_bytes = in_last ? 2'(len - 1 - 4*w) : 2'(w);
            in_valid = 1'b1;
            forever begin
                ok = in_ready;
                @(posedge wr_clk);
                if (ok) break;
                @(negedge wr_clk);
            end
        end
        frame_done[id] = 1'b1;
        @(negedge wr_clk); in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge tx_clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin : main
        repeat (3) @(negedge tx_clk);
        chk(tx_en == 0 && tx_er == 0 && txd == 0, "R11 outputs in reset",
            int'({tx_en, tx_er, txd}), 0);
        chk(in_ready == 1, "R11 ready in reset", int'(in_ready), 1);
        wr_rst_n = 1'b1; tx_rst_n = 1'b1;
        repeat (4) @(negedge tx_clk);
        chk(tx_en == 0 && tx_er == 0 && txd == 0, "R11 outputs after reset",
            int'({tx_en, tx_er, txd}), 0);
        chk(in_ready == 1, "R11 ready after reset", int'(in_ready), 1);
        model_on = 1;

        // R3: final-word counts 1..4, back to back for R9
        send_frame(1, 0, -1, 0, 0);
        send_frame(2, 0, -1, 0, 0);
        send_frame(3, 0, -1, 0, 0);
        send_frame(4, 0, -1, 0, 0);
        send_frame(5, 0, -1, 0, 0);
        send_frame(7, 0, -1, 0, 0);
        // R6: short frame written slowly
        send_frame(12, 1, -1, 0, 20);
        // R10: full-rate frames; R1: long frame fills the FIFO
        send_frame(64, 0, -1, 0, 0);
        send_frame(200, 0, -1, 0, 0);
        // R7 R8: long frame stalled after six words
        send_frame(80, 2, 6, 300, 0);
        send_frame(9, 0, -1, 0, 0);
        send_frame(33, 0, -1, 0, 0);

        for (int t = 0; t < 20000 && (exp_len.size() != 0 || in_fr); t++) @(negedge tx_clk);
        repeat (30) @(negedge tx_clk);

        chk(frames_out == nwr, "R2 frame count", frames_out, nwr);
        chk(errs_out == 1, "R8 error count", errs_out, 1);
        chk(exp_b.size() == 0, "R1 bytes left unsent", exp_b.size(), 0);
        chk(ready_low > 0, "R1 backpressure seen", ready_low, 1);
        chk(in_ready == 1, "R1 ready after drain", int'(in_ready), 1);
        chk(tx_en == 0 && tx_er == 0, "R9 idle at end", int'({tx_en, tx_er}), 0);
        finish_run();
    end
endmodule